// File: doc/BRIEF.md
# Manchester Line Repeater with Sync Classification and Held Downstream Reset

This block takes a serial Manchester stream that arrives without a clock, samples it with a local clock that runs 16 or 32 times faster than the bit rate, and sends it out again on two complementary outputs. The regenerated line lags the input by half a bit period. A second output is a square wave at twice the bit rate. It is rebuilt from the line transitions, and its rising edges fall on the output data edges, so a downstream stage can clock the regenerated line with it.

While it repeats the line, the block also watches it for a sync pattern. A sync is three half-bit cells at one level followed by three half-bit cells at the other level. The block remembers whether the last sync it saw was a command sync (high first) or a data sync (low first). It also drives a held serial-reset output. This output drops whenever the block is reset and rises again only after a sync whose next two bits are both well-formed and whose first bit (the reset bit) is zero. A clear-to-send input gates the outputs to an idle state. A change on clear-to-send never starts a preamble.

Top module: `manchester_repeater`

## Requirements
- R1: With `cts` low, `rep_pos` equals the value of `line_in` sampled exactly H clock cycles earlier, and `rep_neg` is its complement. H is 8 when `speed_sel` is 0 (16X) and 16 when `speed_sel` is 1 (32X).
- R2: With `cts` low, `clk2x_out` is high for the H/2 cycles that start at each change of the repeated data and low for the next H/2 cycles. If no data change occurs, it keeps repeating with period H.
- R3: While `cts` is high, `rep_pos` and `rep_neg` are both 1 and `clk2x_out` is 0. A falling `cts` on an idle line leaves the repeated output idle and emits no preamble.
- R4: `sync_kind` goes to 1 after a command sync (3 half-bit cells high, then 3 low). It goes to 0 after a data sync (3 low, then 3 high). It holds its value until the next sync. One extra half cell of the same level may adjoin either side of the sync.
- R5: `srst_out` is 0 while `rst_n` is low. It stays 0 after `rst_n` returns high until a release occurs. Manchester data without a sync does not release it.
- R6: A release needs a sync followed by two valid bits, each with a mid-bit transition. A bit with first half high is a 1, and a bit with first half low is a 0. If either bit lacks its mid-bit transition, `srst_out` stays 0. Once released, `srst_out` stays 1 until the next reset.
- R7: The first bit after the sync is the reset bit, and it must be 0 for a release. If it is 1, `srst_out` stays 0 and the block waits for the next sync.
- R8: Decoding uses a half-bit cell of H cycles chosen by `speed_sel`. A run on the line counts as round(length/H) half cells, within a tolerance of H/2 cycles. A frame timed for the other rate does not release `srst_out`.
- R9: `sync_kind` is 0 while `rst_n` is low and after reset until the first sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, 16 or 32 times the bit rate |
| rst_n | input | 1 | Active-low asynchronous reset; also drops the serial-reset output |
| speed_sel | input | 1 | 0: 16 samples per bit, 1: 32 samples per bit |
| cts | input | 1 | Clear to send; high forces the outputs to idle |
| line_in | input | 1 | Received Manchester stream, not inverted |
| rep_pos | output | 1 | Regenerated line, half a bit late |
| rep_neg | output | 1 | Complement of the regenerated line |
| clk2x_out | output | 1 | Recovered clock at twice the bit rate |
| sync_kind | output | 1 | 1: last sync was a command sync, 0: data sync |
| srst_out | output | 1 | Held downstream reset, released by sync plus zero reset bit |

## Verification
Each frame is driven at both rates, with a ±2-cycle skew on the half cells. This shows that the delay and the recovered clock follow the real transitions rather than a free-running count. Command and data syncs are sent in turn, each followed by a zero reset bit, a one reset bit, or a bit with no mid-bit transition. This separates sync typing from release qualification and shows that a bad bit or a set reset bit leaves the output held. A clear-to-send window on an active line, an idle fall of clear-to-send, a reset pulse followed by sync-free data, and frames timed for the wrong rate complete the set. Each one isolates gating, the absence of a preamble, the hold after reset, and rate selection.

// File: rtl/mrep_pkg.sv
package mrep_pkg;

   typedef enum logic {
      ST_HUNT    = 1'b0,
      ST_COLLECT = 1'b1
   } dec_state_t;

   typedef logic [2:0] halves_t;

   localparam halves_t NH_NONE = 3'd0;
   localparam halves_t NH_MAX  = 3'd4;

   // true for a run that can hold one side of a sync (3 cells, or 3 plus one adjoining)
   function automatic logic is_long_run(input halves_t n);
      return (n == 3'd3) || (n == 3'd4);
   endfunction

endpackage

// File: rtl/mrep_sampler.sv
module mrep_sampler #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned TAP_LO      = 5,
   parameter int unsigned TAP_HI      = 13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic speed_sel,
   input  logic line_in,
   output logic lvl,
   output logic tap
);

   logic [SYNC_STAGES-1:0] sq;
   logic [TAP_HI:0]        dly;

   // input synchronizer
   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sq[0] <= 1'b0;
            else        sq[0] <= line_in;
         end
      end else begin : g_rest
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sq[g] <= 1'b0;
            else        sq[g] <= sq[g-1];
         end
      end
   end

   assign lvl = sq[SYNC_STAGES-1];

   // half-bit delay line, long enough for the slower sampling rate
   for (genvar d = 0; d <= TAP_HI; d++) begin : g_dly
      if (d == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dly[0] <= 1'b0;
            else        dly[0] <= lvl;
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) dly[d] <= 1'b0;
            else        dly[d] <= dly[d-1];
         end
      end
   end

   assign tap = speed_sel ? dly[TAP_HI] : dly[TAP_LO];

endmodule

// File: rtl/mrep_clkgen.sv
module mrep_clkgen #(
   parameter int unsigned H_LO = 8,
   parameter int unsigned H_HI = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic speed_sel,
   input  logic tap,
   output logic data_q,
   output logic clk_q
);

   localparam int unsigned PH_W = $clog2(H_HI);

   logic [PH_W-1:0] ph, ph_nx, ph_last, ph_half;
   logic            trans;

   assign ph_last = speed_sel ? PH_W'(H_HI - 1) : PH_W'(H_LO - 1);
   assign ph_half = speed_sel ? PH_W'(H_HI / 2) : PH_W'(H_LO / 2);
   assign trans   = tap != data_q;

   always_comb begin
      if (trans)                ph_nx = '0;
      else if (ph == ph_last)   ph_nx = '0;
      else                      ph_nx = ph + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= 1'b0;
         ph     <= '0;
         clk_q  <= 1'b0;
      end else begin
         data_q <= tap;
         ph     <= ph_nx;
         clk_q  <= ph_nx < ph_half;
      end
   end

   // every repeated data edge lands while the recovered clock is high
   assert_edge_on_clk_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (data_q != $past(data_q)) |-> clk_q);

   // the clock never stays high past half a cell without a data edge
   assert_clk_low_half_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(clk_q)) |-> (data_q == $past(data_q)));

endmodule

// File: rtl/mrep_syncdet.sv
module mrep_syncdet
   import mrep_pkg::*;
#(
   parameter int unsigned H_LO = 8,
   parameter int unsigned H_HI = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic speed_sel,
   input  logic lvl,
   output logic sync_kind,
   output logic srst
);

   localparam int unsigned RUN_W = $clog2(H_HI * 6);
   localparam int unsigned SH_LO = $clog2(H_LO);
   localparam int unsigned SH_HI = $clog2(H_HI);
   localparam logic [RUN_W-1:0] RUN_SAT = '1;

   logic             lvl_q;
   logic             edge_w;
   logic [RUN_W-1:0] run_cnt;
   logic [RUN_W:0]   rnd, halves_raw;
   halves_t          nh, prev_n;
   logic             sync_hit;
   dec_state_t       st, st_nx;
   logic [3:0]       hb_q, hb_nx;
   halves_t          bcnt, cnt_nx;
   logic             release_w;

   assign edge_w = lvl ^ lvl_q;

   // run length to half-cell count, rounded to nearest
   assign rnd        = speed_sel ? ({1'b0, run_cnt} + (RUN_W+1)'(H_HI / 2))
                                 : ({1'b0, run_cnt} + (RUN_W+1)'(H_LO / 2));
   assign halves_raw = speed_sel ? (rnd >> SH_HI) : (rnd >> SH_LO);
   assign nh         = (halves_raw >= (RUN_W+1)'(1) && halves_raw <= (RUN_W+1)'(NH_MAX))
                       ? halves_raw[2:0] : NH_NONE;

   assign sync_hit = edge_w && is_long_run(prev_n) && is_long_run(nh);

   always_comb begin
      st_nx     = st;
      hb_nx     = hb_q;
      cnt_nx    = bcnt;
      release_w = 1'b0;
      if (edge_w) begin
         if (sync_hit) begin
            st_nx  = ST_COLLECT;
            hb_nx  = 4'b0000;
            cnt_nx = nh - 3'd3;
            if (nh == 3'd4) hb_nx[0] = lvl_q;
         end else if (st == ST_COLLECT) begin
            if (nh == NH_NONE || nh > 3'd2) begin
               st_nx = ST_HUNT;
            end else begin
               for (int i = 0; i < 2; i++) begin
                  for (int j = 0; j < 4; j++) begin
                     if (3'(i) < nh && 3'(j) == bcnt + 3'(i)) hb_nx[j] = lvl_q;
                  end
               end
               cnt_nx = bcnt + nh;
               if (cnt_nx >= 3'd4) begin
                  st_nx     = ST_HUNT;
                  release_w = (hb_nx[0] != hb_nx[1]) && (hb_nx[2] != hb_nx[3]) && !hb_nx[0];
               end
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q     <= 1'b0;
         run_cnt   <= '0;
         prev_n    <= NH_NONE;
         st        <= ST_HUNT;
         hb_q      <= '0;
         bcnt      <= '0;
         sync_kind <= 1'b0;
         srst      <= 1'b0;
      end else begin
         lvl_q   <= lvl;
         if (edge_w)                  run_cnt <= RUN_W'(1);
         else if (run_cnt != RUN_SAT) run_cnt <= run_cnt + 1'b1;
         if (edge_w) prev_n <= nh;
         st   <= st_nx;
         hb_q <= hb_nx;
         bcnt <= cnt_nx;
         if (sync_hit)  sync_kind <= !lvl_q;
         if (release_w) srst      <= 1'b1;
      end
   end

   assert_kind_only_on_sync_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (sync_kind != $past(sync_kind)) |-> $past(sync_hit));

   assert_srst_held_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> srst);

   assert_release_after_sync_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(srst) |-> $past(st == ST_COLLECT));

   assert_release_zero_bit_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(srst) |-> $past(hb_nx[0] == 1'b0));

endmodule

// File: rtl/manchester_repeater.sv
module manchester_repeater #(
   parameter int unsigned OVS_LO      = 16,
   parameter int unsigned OVS_HI      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic speed_sel,
   input  logic cts,
   input  logic line_in,
   output logic rep_pos,
   output logic rep_neg,
   output logic clk2x_out,
   output logic sync_kind,
   output logic srst_out
);

   localparam int unsigned H_LO   = OVS_LO / 2;
   localparam int unsigned H_HI   = OVS_HI / 2;
   localparam int unsigned TAP_LO = H_LO - SYNC_STAGES - 1;
   localparam int unsigned TAP_HI = H_HI - SYNC_STAGES - 1;

   if ((OVS_LO & (OVS_LO - 1)) != 0 || (OVS_HI & (OVS_HI - 1)) != 0) begin : g_chk_pow2
      $error("oversampling rates must be powers of two");
   end
   if (OVS_HI <= OVS_LO) begin : g_chk_order
      $error("OVS_HI must exceed OVS_LO");
   end
   if (SYNC_STAGES < 1 || H_LO < SYNC_STAGES + 2) begin : g_chk_sync
      $error("half cell too short for the synchronizer depth");
   end

   logic lvl, tap, data_q, clk_q;

   mrep_sampler #(
      .SYNC_STAGES(SYNC_STAGES),
      .TAP_LO     (TAP_LO),
      .TAP_HI     (TAP_HI)
   ) u_sampler (
      .clk      (clk),
      .rst_n    (rst_n),
      .speed_sel(speed_sel),
      .line_in  (line_in),
      .lvl      (lvl),
      .tap      (tap)
   );

   mrep_clkgen #(
      .H_LO(H_LO),
      .H_HI(H_HI)
   ) u_clkgen (
      .clk      (clk),
      .rst_n    (rst_n),
      .speed_sel(speed_sel),
      .tap      (tap),
      .data_q   (data_q),
      .clk_q    (clk_q)
   );

   mrep_syncdet #(
      .H_LO(H_LO),
      .H_HI(H_HI)
   ) u_syncdet (
      .clk      (clk),
      .rst_n    (rst_n),
      .speed_sel(speed_sel),
      .lvl      (lvl),
      .sync_kind(sync_kind),
      .srst     (srst_out)
   );

   // clear-to-send only gates; it has no path into the decoder
   assign rep_pos   = cts | data_q;
   assign rep_neg   = cts | ~data_q;
   assign clk2x_out = ~cts & clk_q;

endmodule

// File: tb/test_manchester_repeater.sv
module test_manchester_repeater;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic speed_sel = 1'b0;
   logic cts = 1'b0;
   logic line_in = 1'b0;
   logic rep_pos, rep_neg, clk2x_out, sync_kind, srst_out;

   always #2.5 clk = ~clk;

   manchester_repeater i_manchester_repeater (
      .clk(clk), .rst_n(rst_n), .speed_sel(speed_sel), .cts(cts), .line_in(line_in),
      .rep_pos(rep_pos), .rep_neg(rep_neg), .clk2x_out(clk2x_out),
      .sync_kind(sync_kind), .srst_out(srst_out)
   );

   int n_run = 0, n_fail = 0;
   int mon_h = 8;     // half cell seen by the monitor
   int drv_h = 8;     // half cell used to drive
   int jit = 2;
   bit done = 0;

   // line history and reference model for R1/R2/R3
   logic hist [0:255];
   int   k = 0, bph = 0;
   logic pexp = 1'b0;
   int   e_dat = 0, e_clk = 0, e_gate = 0;
   logic a_dat, x_dat, a_clk, x_clk;

   initial forever begin
      @(posedge clk);
      #1;
      if (!rst_n) begin
         k = 0; bph = 0; pexp = 1'b0;
         for (int i = 0; i < 256; i++) hist[i] = 1'b0;
      end else begin
         logic ed, ec;
         k++;
         hist[k % 256] = line_in;
         ed = (k >= mon_h) ? hist[(k - mon_h) % 256] : 1'b0;
         if (ed != pexp) bph = 0;
         else            bph = (bph == mon_h - 1) ? 0 : bph + 1;
         pexp = ed;
         ec = (bph < mon_h / 2);
         if (cts) begin
            if (!(rep_pos && rep_neg && !clk2x_out)) e_gate++;
         end else begin
            if (rep_pos !== ed || rep_neg !== !ed) begin
               if (e_dat == 0) begin a_dat = rep_pos; x_dat = ed; end
               e_dat++;
            end
            if (clk2x_out !== ec) begin
               if (e_clk == 0) begin a_clk = clk2x_out; x_clk = ec; end
               e_clk++;
            end
         end
      end
   end

   task automatic check(input string req, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic check_stream(input string tag);
      n_run += 3;
      if (e_dat != 0) begin
         n_fail++;
         $display("FAIL R1 %s repeated data actual=%0b expected=%0b (%0d cycles off)", tag, a_dat, x_dat, e_dat);
      end
      if (e_clk != 0) begin
         n_fail++;
         $display("FAIL R2 %s recovered clock actual=%0b expected=%0b (%0d cycles off)", tag, a_clk, x_clk, e_clk);
      end
      if (e_gate != 0) begin
         n_fail++;
         $display("FAIL R3 %s gated outputs actual=not-idle expected=idle (%0d cycles)", tag, e_gate);
      end
      e_dat = 0; e_clk = 0; e_gate = 0;
   endtask

   task automatic half(input logic v, input int extra);
      line_in = v;
      repeat (drv_h + extra) @(negedge clk);
   endtask

   task automatic send_bit(input logic v);
      jit = -jit;
      half(v, jit);
      half(!v, -jit);
   endtask

   task automatic send_sync(input logic cmd);
      line_in = cmd;
      repeat (3 * drv_h) @(negedge clk);
      line_in = !cmd;
      repeat (3 * drv_h) @(negedge clk);
   endtask

   task automatic do_reset(input logic sp);
      @(negedge clk);
      rst_n = 1'b0; line_in = 1'b0; cts = 1'b0; speed_sel = sp;
      mon_h = sp ? 16 : 8; drv_h = mon_h;
      repeat (4) @(negedge clk);
      check("R5 srst low in reset", srst_out, 1'b0);
      check("R9 sync_kind low in reset", sync_kind, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      for (int sp = 0; sp < 2; sp++) begin
         do_reset(sp[0]);
         check("R5 srst low after reset", srst_out, 1'b0);
         check("R9 sync_kind low after reset", sync_kind, 1'b0);

         // R3: gating while data flows, then idle fall of cts
         cts = 1'b1;
         send_bit(1); send_bit(0); send_bit(1); send_bit(1);
         line_in = 1'b0;
         repeat (2 * mon_h) @(negedge clk);
         cts = 1'b0;
         begin
            int chg = 0;
            logic last = rep_pos;
            repeat (4 * mon_h) begin
               @(negedge clk);
               if (rep_pos !== last) chg++;
               last = rep_pos;
            end
            n_run++;
            if (chg != 0 || last !== 1'b0) begin
               n_fail++;
               $display("FAIL R3 no preamble actual=%0d edges expected=0 edges", chg);
            end
         end
         check_stream("cts window");

         // R4/R7: command sync with reset bit one
         send_bit(1); send_bit(0); send_bit(1); send_bit(1);
         send_sync(1'b1);
         send_bit(1); send_bit(0); send_bit(1); send_bit(0);
         check("R4 command sync kind", sync_kind, 1'b1);
         check("R7 reset bit one holds srst", srst_out, 1'b0);

         // R4/R6: data sync, zero reset bit, malformed second bit
         send_bit(0); send_bit(1);
         send_sync(1'b0);
         send_bit(0);
         half(1'b1, 0); half(1'b1, 0);
         send_bit(1); send_bit(0);
         check("R4 data sync kind", sync_kind, 1'b0);
         check("R6 bad second bit holds srst", srst_out, 1'b0);
         check_stream("frames A");

         // R6/R7: command sync, reset bit zero, valid second bit
         send_bit(1); send_bit(1);
         send_sync(1'b1);
         send_bit(0); send_bit(1); send_bit(1); send_bit(0);
         check("R6 release after sync and zero bit", srst_out, 1'b1);
         check("R4 kind after release frame", sync_kind, 1'b1);

         // later data sync changes kind, srst stays released
         send_sync(1'b0);
         send_bit(1); send_bit(1);
         check("R4 data sync after command", sync_kind, 1'b0);
         check("R6 srst stays released", srst_out, 1'b1);
         check_stream("frames B");

         // R5: reset drops srst and data without sync does not release
         do_reset(sp[0]);
         send_bit(0); send_bit(1); send_bit(1); send_bit(0); send_bit(0);
         check("R5 no release without sync", srst_out, 1'b0);
         send_sync(1'b1);
         send_bit(0); send_bit(0); send_bit(1);
         check("R6 release after reset", srst_out, 1'b1);
         check("R4 command after reset", sync_kind, 1'b1);
         check_stream("frames C");

         // R8: frame timed for the other rate
         do_reset(sp[0]);
         drv_h = sp ? 8 : 16;
         send_bit(1); send_bit(0);
         send_sync(1'b1);
         send_bit(0); send_bit(1); send_bit(0); send_bit(1);
         check("R8 wrong-rate frame ignored", srst_out, 1'b0);
         check("R8 wrong-rate sync ignored", sync_kind, 1'b0);
         drv_h = mon_h;
         line_in = 1'b0;
         repeat (2 * mon_h) @(negedge clk);
         check_stream("wrong rate");
      end
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule